// File: doc/BRIEF.md
# EEPROM Storage Sequence Controller

This controller replays a short command script into an external EEPROM, one byte at a time. A start pulse makes it read the script from slot 0 upward. It writes every byte it finds to the EEPROM location named by an internal address pointer. It also folds each byte into a running CRC-32. Most byte values are plain one-byte action opcodes: 0x80 updates the registers, 0x92 calibrates every analog PLL, and 0xA0 synchronizes all output dividers. Any other value that is not a terminator is treated the same way. Each of these is stored unchanged and the pointer moves on by one.

Two byte values end a profile: 0xFF (end) and 0xFE (pause). The terminator is stored, and four CRC bytes follow it. Then the controller goes idle. After an end the pointer returns to zero. After a pause it stays just past the CRC trailer, so the next run lays a second profile directly behind the first. If the script runs past its last slot without a terminator, the run is aborted. An error flag is raised and the pointer is put back to its value at the start of the run.

The state machine has four states:
- IDLE: waiting for start.
- FETCH: latches the script byte.
- STORE: requests the write of the script byte.
- TRAIL: requests the writes of the four CRC bytes.

The transitions are:
- IDLE to FETCH on start.
- FETCH to STORE always.
- STORE to FETCH on acknowledge of a non-terminator.
- STORE to TRAIL on acknowledge of a terminator.
- STORE to IDLE on acknowledge of a non-terminator in the last slot (overflow).
- TRAIL to IDLE on acknowledge of the fourth CRC byte.

Top module: `eeprom_seq_ctrl`

## Requirements
- R1: After reset the controller is idle: busy, done, error and request are low and the address output, which always shows the pointer, is zero.
- R2: A script byte other than 0xFF or 0xFE (for example 0x80, 0x92, 0xA0) is written unchanged at the current pointer, and the pointer then increases by one.
- R3: A terminator byte (0xFF or 0xFE) is written and is followed by four more writes holding the CRC-32 least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from 0xFFFFFFFF and is inverted at the end. It covers every byte of the current run, terminator included.
- R4: When the trailer of an 0xFF run is complete, the pointer is zero. When the trailer of an 0xFE run is complete, the pointer is one past the last trailer byte.
- R5: A write request stays high with stable address and data until the acknowledge arrives. Each acknowledge consumes exactly one byte.
- R6: If the non-terminator in the last script slot is stored, the run stops. The error output goes high, done stays low and the pointer returns to its value at start. The error output is cleared by the next start.
- R7: Done is a one-cycle pulse raised as the controller returns to idle after a trailer. Busy is high from the cycle after an accepted start until the return to idle.
- R8: A start pulse while busy is ignored.
- R9: Every run reads the script from slot 0 in increasing order, and each run starts a fresh CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| scr_idx_o | output | IDX_W | Script slot being read |
| scr_data_i | input | 8 | Script byte at scr_idx_o |
| ee_req_o | output | 1 | EEPROM byte write request |
| ee_addr_o | output | EE_ADDR_W | EEPROM address (pointer) |
| ee_data_o | output | 8 | EEPROM write byte |
| ee_ack_i | input | 1 | Write acknowledge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run completed pulse |
| err_o | output | 1 | Script overflow flag |

## Verification
The main function is tried with several scripts:
- The default action script closed by an end byte shows that the bytes are stored unchanged and that the pointer resets.
- A pause-terminated profile followed by an end-terminated one starting at the advanced pointer separates the two pointer rules. It also shows that the CRC restarts for each profile.
- A script of unusual opcode values (0x00, 0x5A) shows that non-listed bytes are stored like actions.
- A script with no terminator at all drives the overflow abort with a nonzero starting pointer, so that restoring the pointer can be told apart from resetting it.
- A start pulse in the middle of a run shows that the write sequence is not disturbed.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_STORE = 2'd2,
        S_TRAIL = 2'd3
    } seq_state_t;

    localparam logic [7:0] OP_END   = 8'hFF;
    localparam logic [7:0] OP_PAUSE = 8'hFE;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

    function automatic logic [31:0] crc_step(input logic [31:0] acc, input logic [7:0] b);
        logic [31:0] r;
        r = acc ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/eeseq_crc.sv
module eeseq_crc
    import eeseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_i,
    input  logic        en_i,
    input  logic [7:0]  byte_i,
    output logic [31:0] crc_o
);
    logic [31:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc_q <= CRC_SEED;
        else if (clr_i) acc_q <= CRC_SEED;
        else if (en_i)  acc_q <= crc_step(acc_q, byte_i);
    end

    assign crc_o = ~acc_q;
endmodule

// File: rtl/eeseq_ptr.sv
module eeseq_ptr #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          zero_i,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    output logic [AW-1:0] ptr_o
);
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr_q <= '0;
        else if (load_i) ptr_q <= load_val_i;
        else if (zero_i) ptr_q <= '0;
        else if (inc_i)  ptr_q <= ptr_q + AW'(1);
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
    import eeseq_pkg::*;
#(
    parameter int SCRIPT_DEPTH = 16,
    parameter int EE_ADDR_W    = 12,
    localparam int IDX_W       = $clog2(SCRIPT_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    output logic [IDX_W-1:0]     scr_idx_o,
    input  logic [7:0]           scr_data_i,
    output logic                 ee_req_o,
    output logic [EE_ADDR_W-1:0] ee_addr_o,
    output logic [7:0]           ee_data_o,
    input  logic                 ee_ack_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCRIPT_DEPTH - 1);

    seq_state_t state_q, state_d;
    logic [IDX_W-1:0]     idx_q;
    logic [7:0]           byte_q;
    logic [1:0]           trl_q;
    logic                 is_end_q;
    logic [EE_ADDR_W-1:0] start_ptr_q;
    logic                 done_q, err_q;

    logic                 take_start, store_ack, trail_ack, is_term, overflow, last_trl;
    logic [31:0]          crc_val;
    logic [EE_ADDR_W-1:0] ptr;

    assign take_start = (state_q == S_IDLE) && start_i;
    assign store_ack  = (state_q == S_STORE) && ee_ack_i;
    assign trail_ack  = (state_q == S_TRAIL) && ee_ack_i;
    assign is_term    = (byte_q == OP_END) || (byte_q == OP_PAUSE);
    assign overflow   = store_ack && !is_term && (idx_q == LAST_IDX);
    assign last_trl   = trail_ack && (trl_q == 2'd3);

    eeseq_crc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (take_start),
        .en_i   (store_ack),
        .byte_i (byte_q),
        .crc_o  (crc_val)
    );

    eeseq_ptr #(.AW(EE_ADDR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (store_ack || trail_ack),
        .zero_i     (last_trl && is_end_q),
        .load_i     (overflow),
        .load_val_i (start_ptr_q),
        .ptr_o      (ptr)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_FETCH;
            S_FETCH: state_d = S_STORE;
            S_STORE: if (ee_ack_i) begin
                         if (is_term)       state_d = S_TRAIL;
                         else if (overflow) state_d = S_IDLE;
                         else               state_d = S_FETCH;
                     end
            S_TRAIL: if (last_trl) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            idx_q       <= '0;
            byte_q      <= '0;
            trl_q       <= '0;
            is_end_q    <= 1'b0;
            start_ptr_q <= '0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= last_trl;
            if (take_start) begin
                idx_q       <= '0;
                err_q       <= 1'b0;
                start_ptr_q <= ptr;
            end
            if (state_q == S_FETCH) byte_q <= scr_data_i;
            if (store_ack) begin
                if (is_term) begin
                    is_end_q <= (byte_q == OP_END);
                    trl_q    <= '0;
                end else if (overflow) begin
                    err_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
            if (trail_ack) trl_q <= trl_q + 2'd1;
        end
    end

    // outputs
    always_comb begin
        scr_idx_o = idx_q;
        ee_addr_o = ptr;
        busy_o    = (state_q != S_IDLE);
        done_o    = done_q;
        err_o     = err_q;
        ee_req_o  = 1'b0;
        ee_data_o = byte_q;
        unique case (state_q)
            S_STORE: ee_req_o = 1'b1;
            S_TRAIL: begin
                ee_req_o  = 1'b1;
                ee_data_o = crc_val[{trl_q, 3'b000} +: 8];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/eeseq_chk.sv
module eeseq_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic          ee_req_o,
    input logic          ee_ack_i,
    input logic [AW-1:0] ee_addr_o,
    input logic [7:0]    ee_data_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req_o && !ee_ack_i) |=> (ee_req_o && $stable(ee_addr_o) && $stable(ee_data_o))); // R5
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req_o && ee_ack_i) |=> (!busy_o || ee_addr_o == $past(ee_addr_o) + AW'(1))); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7
    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!done_o && !busy_o)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ee_req_o); // R1
endmodule

bind eeprom_seq_ctrl eeseq_chk #(.AW(EE_ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .ee_req_o  (ee_req_o),
    .ee_ack_i  (ee_ack_i),
    .ee_addr_o (ee_addr_o),
    .ee_data_o (ee_data_o)
);

// File: tb/eeprom_seq_ctrl_tb.sv
module eeprom_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic ee_ack_i = 1'b0;
    logic [3:0] scr_idx_o;
    logic [7:0] scr_data_i;
    logic ee_req_o, busy_o, done_o, err_o;
    logic [AW-1:0] ee_addr_o;
    logic [7:0] ee_data_o;

    logic [7:0]    script_m [DEPTH];
    logic [7:0]    wlog_d [64];
    logic [AW-1:0] wlog_a [64];
    int wr_cnt = 0;
    int total = 0;
    int bad = 0;
    bit seen_done;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign scr_data_i = script_m[scr_idx_o];

    eeprom_seq_ctrl #(.SCRIPT_DEPTH(DEPTH), .EE_ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .scr_idx_o(scr_idx_o), .scr_data_i(scr_data_i),
        .ee_req_o(ee_req_o), .ee_addr_o(ee_addr_o), .ee_data_o(ee_data_o),
        .ee_ack_i(ee_ack_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    // EEPROM responder: one acknowledge per requested byte
    initial begin
        forever begin
            @(negedge clk);
            if (ee_req_o && !ee_ack_i) begin
                if (wr_cnt < 64) begin
                    wlog_d[wr_cnt] = ee_data_o;
                    wlog_a[wr_cnt] = ee_addr_o;
                end
                wr_cnt++;
                ee_ack_i = 1'b1;
            end else begin
                ee_ack_i = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, script_m[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic run(input int poke_at);
        int cyc = 0;
        wr_cnt = 0;
        seen_done = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        while (busy_o && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (cyc == poke_at) start_i = 1'b1;
            else start_i = 1'b0;
            if (done_o) seen_done = 1;
        end
        start_i = 1'b0;
        if (done_o) seen_done = 1;
    endtask

    // checks a completed profile of n script bytes stored from address sa
    task automatic check_profile(input int n, input int sa, input bit is_end, input string tag);
        logic [31:0] crc = ref_crc(n);
        chk(wr_cnt == n + 4, {tag, " R5 write count"}, wr_cnt, n + 4);
        for (int i = 0; i < n; i++) begin
            chk(wlog_d[i] == script_m[i], {tag, " R2 R9 data"}, wlog_d[i], script_m[i]);
        end
        for (int i = 0; i < n + 4; i++) begin
            chk(wlog_a[i] == AW'(sa + i), {tag, " R2 addr"}, wlog_a[i], sa + i);
        end
        for (int k = 0; k < 4; k++) begin
            chk(wlog_d[n + k] == crc[8*k +: 8], {tag, " R3 crc byte"}, wlog_d[n + k], crc[8*k +: 8]);
        end
        chk(seen_done == 1, {tag, " R7 done"}, seen_done, 1);
        chk(!busy_o && !err_o, {tag, " R7 idle no err"}, {busy_o, err_o}, 0);
        if (is_end) chk(ee_addr_o == 0, {tag, " R4 end ptr"}, ee_addr_o, 0);
        else        chk(ee_addr_o == AW'(sa + n + 4), {tag, " R4 pause ptr"}, ee_addr_o, sa + n + 4);
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o && !err_o && !ee_req_o, "R1 idle outputs", {busy_o, done_o, err_o, ee_req_o}, 0);
        chk(ee_addr_o == 0, "R1 pointer zero", ee_addr_o, 0);
    endtask

    task automatic t_default_end();
        script_m[0] = 8'h80; script_m[1] = 8'h92; script_m[2] = 8'hA0; script_m[3] = 8'hFF;
        run(0);
        check_profile(4, 0, 1, "default");
    endtask

    task automatic t_pause_then_end();
        script_m[0] = 8'h80; script_m[1] = 8'hFE;
        run(0);
        check_profile(2, 0, 0, "pause");
        script_m[0] = 8'h00; script_m[1] = 8'h5A; script_m[2] = 8'h92; script_m[3] = 8'hFF;
        run(0);
        check_profile(4, 6, 1, "after pause");
    endtask

    task automatic t_overflow();
        script_m[0] = 8'hA0; script_m[1] = 8'hFE;
        run(0);
        check_profile(2, 0, 0, "pre overflow");
        for (int i = 0; i < DEPTH; i++) script_m[i] = 8'h11 + 8'(i);
        run(0);
        chk(wr_cnt == DEPTH, "R6 writes before abort", wr_cnt, DEPTH);
        chk(err_o == 1, "R6 error flag", err_o, 1);
        chk(seen_done == 0, "R6 no done", seen_done, 0);
        chk(ee_addr_o == 6, "R6 pointer restored", ee_addr_o, 6);
        chk(wlog_d[DEPTH-1] == 8'h20, "R9 last slot stored", wlog_d[DEPTH-1], 8'h20);
        script_m[0] = 8'h92; script_m[1] = 8'hFF;
        run(0);
        check_profile(2, 6, 1, "R6 err cleared");
    endtask

    task automatic t_start_while_busy();
        script_m[0] = 8'h80; script_m[1] = 8'h92; script_m[2] = 8'hA0; script_m[3] = 8'hFF;
        run(5);
        check_profile(4, 0, 1, "R8 restart ignored");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) script_m[i] = 8'hFF;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_end();
        t_pause_then_end();
        t_overflow();
        t_start_while_busy();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule